// File: doc/BRIEF.md
# Synchronous Burst Read Sequencer

This block is the read-side timing engine of a synchronous burst memory of the NOR style. A host drives an address-valid strobe low together with a start address; the sequencer captures the address, waits a programmable number of initial access cycles and then presents one 16-bit word per clock, with a ready flag that tells the host when a word on the data bus is good.

A command write loads a small configuration register. Address bits 14 to 12 of that write carry a latency code, and bits 1 to 0 pick the burst shape. A fixed burst of 8, 16 or 32 words wraps inside its own aligned window and then releases the bus. A continuous burst walks upward through the address space until the next strobe and pauses for one clock each time it steps out of a 64-word region. The storage array sits outside the block; the block drives its read address and forwards the word that comes back.

Top module: `burst_read_seq`

## Requirements
- R1: After reset the latency is seven initial access cycles, the burst shape is continuous, and both `dout_en` and `rdy` are low until a strobe is seen.
- R2: A write with `cfg_wr` high takes latency code `cfg_addr[14:12]`; codes 0 to 5 give total initial access counts of 2 to 7 in order. The same write takes the shape from `cfg_addr[1:0]`: 0 is 8 words, 1 is 16 words, 2 is 32 words, 3 is continuous.
- R3: A write whose latency code is 6 or 7 is ignored as a whole; both latency and shape keep their previous values.
- R4: The start address is captured on the first rising edge at which `adv_n` is low. With a total access count L, the first word is driven (`dout_en` high, `dout` equal to the array word at the start address) in the cycle that follows the L-1th edge after the capture edge; before that `dout_en` is low.
- R5: For L above 2, `rdy` goes high exactly one cycle before the first word; for L equal to 2, `rdy` first goes high together with the first word. It stays high on every following word.
- R6: In a fixed burst of N words the address advances by one inside its N-aligned window and wraps to the window base, so it never leaves the 64-word region of the start address.
- R7: A fixed burst ends after exactly N words; from the next cycle `dout_en` and `rdy` are low and `dout` is zero.
- R8: In continuous mode the address advances by one each word; after the word at the last address of a 64-word region there is exactly one cycle with `rdy` low before the next word appears.
- R9: A strobe during latency or data transfer aborts the burst, captures the new address and starts the latency count again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| adv_n | input | 1 | Address-valid strobe, active low |
| addr_in | input | AW | Burst start address |
| cfg_wr | input | 1 | Configuration command write strobe |
| cfg_addr | input | 16 | Configuration write address; [14:12] latency code, [1:0] burst shape |
| mem_addr | output | AW | Read address to the storage array |
| mem_rdata | input | 16 | Word returned by the array for `mem_addr` |
| dout | output | 16 | Burst data word, zero while released |
| dout_en | output | 1 | High while the block drives the data bus |
| rdy | output | 1 | High when the current or next word is valid |

## Verification
The hardest state to reach is the continuous-mode region crossing, which only occurs after a run of words ends on an address with its six low bits all ones; the stimulus starts continuous bursts a few words below a 64-word boundary and at the very top of the address space so that the stall appears within a short observation window, at every latency. The second hard case is an abort that lands mid-transfer, reached by cutting an observed burst short and issuing a new strobe on the next cycle. A sweep over every latency code and shape with starts near window edges covers the wrap points, and a reserved-code write followed by a burst shows from the ports that nothing changed.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LAT   = 2'd1,
        ST_DATA  = 2'd2,
        ST_STALL = 2'd3
    } seq_state_e;

    typedef enum logic [1:0] {
        BM_W8   = 2'd0,
        BM_W16  = 2'd1,
        BM_W32  = 2'd2,
        BM_CONT = 2'd3
    } burst_mode_e;

    localparam logic [2:0] LAT_CODE_MAX = 3'd5;   // highest legal code
    localparam logic [2:0] LAT_BASE     = 3'd2;   // code 0 means two cycles

    function automatic logic [5:0] burst_words(input burst_mode_e m);
        case (m)
            BM_W8:   return 6'd8;
            BM_W16:  return 6'd16;
            BM_W32:  return 6'd32;
            default: return 6'd0;
        endcase
    endfunction

endpackage

// File: rtl/burst_cfg_reg.sv
module burst_cfg_reg
    import burst_seq_pkg::*;
#(
    parameter logic [2:0]  DEF_CODE = 3'd5,
    parameter burst_mode_e DEF_MODE = BM_CONT
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [2:0]  wr_code,
    input  logic [1:0]  wr_mode,
    output logic [2:0]  lat_total,
    output burst_mode_e mode
);

    typedef struct packed {
        logic [2:0]  code;
        burst_mode_e mode;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (wr_en && (wr_code <= LAT_CODE_MAX)) begin
            cfg_d.code = wr_code;
            cfg_d.mode = burst_mode_e'(wr_mode);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q.code <= DEF_CODE;
            cfg_q.mode <= DEF_MODE;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign lat_total = cfg_q.code + LAT_BASE;
    assign mode      = cfg_q.mode;

    // R3: reserved latency codes leave the stored setting alone
    p_reserved_kept_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_code > LAT_CODE_MAX) |=> ($stable(cfg_q)));

endmodule

// File: rtl/burst_ptr_step.sv
module burst_ptr_step
    import burst_seq_pkg::*;
#(
    parameter int AW       = 16,
    parameter int REGION_W = 6
) (
    input  logic [AW-1:0] ptr,
    input  burst_mode_e   mode,
    output logic [AW-1:0] nxt,
    output logic          region_end
);

    localparam logic [AW-1:0] MASK8  = AW'(7);
    localparam logic [AW-1:0] MASK16 = AW'(15);
    localparam logic [AW-1:0] MASK32 = AW'(31);

    logic [AW-1:0] mask;
    logic [AW-1:0] inc;

    always_comb begin
        case (mode)
            BM_W8:   mask = MASK8;
            BM_W16:  mask = MASK16;
            BM_W32:  mask = MASK32;
            default: mask = '1;
        endcase
        inc = ptr + AW'(1);
        nxt = (ptr & ~mask) | (inc & mask);
    end

    assign region_end = &ptr[REGION_W-1:0];

endmodule

// File: rtl/burst_read_seq.sv
module burst_read_seq
    import burst_seq_pkg::*;
#(
    parameter int AW       = 16,
    parameter int REGION_W = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          adv_n,
    input  logic [AW-1:0] addr_in,
    input  logic          cfg_wr,
    input  logic [15:0]   cfg_addr,
    output logic [AW-1:0] mem_addr,
    input  logic [15:0]   mem_rdata,
    output logic [15:0]   dout,
    output logic          dout_en,
    output logic          rdy
);

    typedef struct packed {
        seq_state_e    st;
        logic [2:0]    cnt;
        logic [AW-1:0] ptr;
        logic [5:0]    left;
        burst_mode_e   mode;
        logic          early;
    } seq_t;

    seq_t s_d, s_q;

    logic [2:0]    lat_total;
    burst_mode_e   cfg_mode;
    logic [AW-1:0] ptr_nxt;
    logic          region_end;

    burst_cfg_reg u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (cfg_wr),
        .wr_code   (cfg_addr[14:12]),
        .wr_mode   (cfg_addr[1:0]),
        .lat_total (lat_total),
        .mode      (cfg_mode)
    );

    burst_ptr_step #(.AW(AW), .REGION_W(REGION_W)) u_step (
        .ptr        (s_q.ptr),
        .mode       (s_q.mode),
        .nxt        (ptr_nxt),
        .region_end (region_end)
    );

    always_comb begin
        s_d = s_q;
        if (!adv_n) begin
            s_d.st    = ST_LAT;
            s_d.cnt   = lat_total - 3'd1;
            s_d.ptr   = addr_in;
            s_d.mode  = cfg_mode;
            s_d.early = (lat_total > LAT_BASE);
            s_d.left  = burst_words(cfg_mode);
        end else begin
            case (s_q.st)
                ST_LAT: begin
                    if (s_q.cnt == 3'd1) s_d.st = ST_DATA;
                    else                 s_d.cnt = s_q.cnt - 3'd1;
                end
                ST_DATA: begin
                    s_d.ptr = ptr_nxt;
                    if (s_q.mode == BM_CONT) begin
                        if (region_end) s_d.st = ST_STALL;
                    end else begin
                        s_d.left = s_q.left - 6'd1;
                        if (s_q.left == 6'd1) s_d.st = ST_IDLE;
                    end
                end
                ST_STALL: s_d.st = ST_DATA;
                default:  s_d.st = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{st: ST_IDLE, cnt: 3'd0, ptr: '0, left: 6'd0,
                     mode: BM_CONT, early: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    assign mem_addr = s_q.ptr;
    assign dout_en  = (s_q.st == ST_DATA) || (s_q.st == ST_STALL);
    assign dout     = (s_q.st == ST_DATA) ? mem_rdata : 16'h0000;
    assign rdy      = (s_q.st == ST_DATA) ||
                      ((s_q.st == ST_LAT) && (s_q.cnt == 3'd1) && s_q.early);

    // R6: a fixed burst keeps the pointer inside its 64-word region
    p_fixed_region_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == ST_DATA && s_q.mode != BM_CONT && adv_n)
        |=> (mem_addr[AW-1:REGION_W] == $past(mem_addr[AW-1:REGION_W])));

    // R8: a boundary stall lasts exactly one cycle
    p_stall_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == ST_STALL && adv_n) |=> (rdy && dout_en));

    // R8: the stall holds ready low while the bus stays driven
    p_stall_rdy_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == ST_STALL) |-> (!rdy && dout_en));

    // R5: an early ready is followed by the first word on the next cycle
    p_ready_lead_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rdy && !dout_en && adv_n) |=> (rdy && dout_en));

    // R7: a fixed burst never presents a word with no count left
    p_count_live_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == ST_DATA && s_q.mode != BM_CONT) |-> (s_q.left != 6'd0));

endmodule

// File: tb/tb_burst_read_seq.sv
`timescale 1ns/1ps
module tb_burst_read_seq;

    localparam int AW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          adv_n = 1'b1;
    logic [AW-1:0] addr_in = '0;
    logic          cfg_wr = 1'b0;
    logic [15:0]   cfg_addr = '0;
    logic [AW-1:0] mem_addr;
    logic [15:0]   mem_rdata;
    logic [15:0]   dout;
    logic          dout_en;
    logic          rdy;

    int n_tests = 0;
    int n_fail  = 0;

    always #2.5 clk = ~clk;

    function automatic logic [15:0] word_at(input logic [15:0] a);
        return {a[7:0], a[15:8]} ^ 16'hC3A5;
    endfunction

    assign mem_rdata = word_at(mem_addr);

    burst_read_seq #(.AW(AW)) dut (
        .clk(clk), .rst_n(rst_n), .adv_n(adv_n), .addr_in(addr_in),
        .cfg_wr(cfg_wr), .cfg_addr(cfg_addr), .mem_addr(mem_addr),
        .mem_rdata(mem_rdata), .dout(dout), .dout_en(dout_en), .rdy(rdy)
    );

    task automatic check(input string tag, input logic [15:0] got_d,
                         input logic got_en, input logic got_r,
                         input logic [15:0] exp_d, input logic exp_en,
                         input logic exp_r, input bit cmp_d);
        n_tests++;
        if (got_en !== exp_en || got_r !== exp_r || (cmp_d && got_d !== exp_d)) begin
            n_fail++;
            $display("FAIL %s: en=%b rdy=%b dout=%h, expected en=%b rdy=%b dout=%h",
                     tag, got_en, got_r, got_d, exp_en, exp_r, exp_d);
        end
    endtask

    task automatic cfg_write(input logic [2:0] code, input logic [1:0] shape);
        @(negedge clk);
        cfg_wr = 1'b1;
        cfg_addr = {1'b0, code, 10'd0, shape};
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    // Issue a strobe, then check ncyc cycles against the arithmetic model.
    task automatic run_burst(input string tag, input int lat, input int shape,
                             input logic [15:0] start, input int ncyc);
        int nw;
        int served;
        bit stall;
        logic [15:0] ea;
        nw = (shape == 0) ? 8 : (shape == 1) ? 16 : (shape == 2) ? 32 : 0;
        served = 0;
        stall = 1'b0;
        ea = start;
        @(negedge clk);
        adv_n = 1'b0;
        addr_in = start;
        @(posedge clk);
        @(negedge clk);
        adv_n = 1'b1;
        for (int c = 0; c < ncyc; c++) begin
            if (c > 0) @(negedge clk);
            #0.5;
            if (c < lat - 2) begin
                check({tag, " R4 latency"}, dout, dout_en, rdy, 16'h0, 1'b0, 1'b0, 1'b0);
            end else if (c == lat - 2) begin
                check({tag, " R5 early ready"}, dout, dout_en, rdy, 16'h0, 1'b0, lat > 2, 1'b0);
            end else if (nw != 0 && served >= nw) begin
                check({tag, " R7 burst end"}, dout, dout_en, rdy, 16'h0, 1'b0, 1'b0, 1'b1);
            end else if (stall) begin
                check({tag, " R8 boundary stall"}, dout, dout_en, rdy, 16'h0, 1'b1, 1'b0, 1'b0);
                stall = 1'b0;
            end else begin
                check({tag, (nw != 0) ? " R6 wrap data" : " R8 linear data"},
                      dout, dout_en, rdy, word_at(ea), 1'b1, 1'b1, 1'b1);
                served++;
                if (nw != 0) begin
                    ea = (ea & ~16'(nw - 1)) | ((ea + 16'd1) & 16'(nw - 1));
                end else begin
                    if (ea[5:0] == 6'h3F) stall = 1'b1;
                    ea = ea + 16'd1;
                end
            end
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        #0.5;
        check("R1 idle after reset", dout, dout_en, rdy, 16'h0, 1'b0, 1'b0, 1'b1);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        #0.5;
        check("R1 idle before strobe", dout, dout_en, rdy, 16'h0, 1'b0, 1'b0, 1'b1);
        // R1: default seven cycles, continuous, crossing at 0x40
        run_burst("R1 default", 7, 3, 16'h003D, 14);

        // R2: sweep every legal code and every shape
        for (int code = 0; code <= 5; code++) begin
            for (int shape = 0; shape < 4; shape++) begin
                cfg_write(3'(code), 2'(shape));
                run_burst("R2 sweep", code + 2, shape,
                          16'h1230 + 16'(code * 4 + shape * 7) + 16'h000B, code + 40);
            end
        end

        // R6: starts on the last word of windows at region edges
        cfg_write(3'd0, 2'd2);
        run_burst("R6 w32 top", 2, 2, 16'hFFFF, 38);
        cfg_write(3'd3, 2'd0);
        run_burst("R6 w8 edge", 5, 0, 16'h013F, 16);

        // R8: continuous crossings, including the top of the space
        cfg_write(3'd0, 2'd3);
        run_burst("R8 cont top", 2, 3, 16'hFFFD, 10);
        cfg_write(3'd4, 2'd3);
        run_burst("R8 cont", 6, 3, 16'h07BE, 12);

        // R3: reserved codes change neither latency nor shape
        cfg_write(3'd1, 2'd1);
        cfg_write(3'd6, 2'd3);
        cfg_write(3'd7, 2'd0);
        run_burst("R3 reserved", 3, 1, 16'h2A09, 22);

        // R9: abort mid-transfer and mid-latency
        cfg_write(3'd2, 2'd3);
        run_burst("R9 first", 4, 3, 16'h0500, 6);
        run_burst("R9 restart", 4, 3, 16'h093E, 10);
        cfg_write(3'd5, 2'd2);
        run_burst("R9 first lat", 7, 2, 16'h0100, 3);
        run_burst("R9 restart lat", 7, 2, 16'h0277, 42);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule